// File: doc/BRIEF.md
# Page Access Rights and Fault Coder

This block sits at the end of a page-table walker. Once the walker has combined the user, writable and no-execute bits of every level it visited and has fetched the leaf entry's dirty bit and protection key, it hands the block that information. The block also receives the walker's own outcome, the privilege of the request, the access type and the paging control bits.

From these inputs the block computes a read/write/execute rights mask. It narrows that mask with the protection-key rights register that applies, either the one for user pages or the one for supervisor pages. It then decides whether the request is allowed. When the request is denied, or when the walker has already failed, the block produces a page-fault error code. When the request is allowed, it reports which of the entry's accessed and dirty bits the walker must set, and it returns the rights that can be cached for the page.

All results are registered and appear one cycle after an input strobe. The block issues no memory traffic of its own.

Top module: `page_rights_unit`

## Requirements
- R1: A user access (`is_user`=1) to a page whose combined user bit is clear faults as a protection violation. This check comes before any key or rights check. The error code has bit 0 (present) set plus the qualifier bits of R8.
- R2: Read right (rights bit 0) is granted unless `sup_guard` is set and the page is a user page.
- R3: Write right (rights bit 1) requires read right and either the page's writable bit or a supervisor access with `wr_protect` clear.
- R4: Execute right (rights bit 2) is granted when the page's NX bit is clear and either the access is a user access or it is not the case that `exec_guard` is set on a user page.
- R5: Key rights come from `ukey_reg` for user pages when `ukey_on` is set, or from `skey_reg` for supervisor pages when `skey_on` is set. Otherwise the register value is taken as zero. A zero register leaves the rights unchanged. The page key k selects register bit 2k (access disable) and bit 2k+1 (write disable).
- R6: Access disable removes read and write. Write disable removes write only for a user access or when `wr_protect` is set. A request denied by the key rights gets error code bit 5 (key) and bit 0 (present).
- R7: `walk_status` 1 (not present) gives a fault whose base code is 0. `walk_status` 2 or 3 (reserved bit) gives base code bit 3. A walker fault takes priority over every rights check.
- R8: A fault's error code also carries bit 2 for a user access and bit 1 for a store. It carries bit 4 for a fetch when `nx_on` or `exec_guard` is set.
- R9: On success, `out_set_acc` is 1 and `out_set_dirty` equals "access is a store". For a non-store to a page whose dirty bit is clear, the write right is removed from `out_rights`.
- R10: `acc_type` is 0 for load, 1 for store and 2 for fetch; code 3 is handled as a load. A request is allowed when the final rights bit at that index is set. On a fault `out_rights`, `out_set_acc` and `out_set_dirty` are 0.
- R11: Results appear on the outputs one clock after `in_valid`. `out_valid` is high for exactly that cycle. The other outputs hold their values while no strobe arrives.
- R12: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| walk_status | input | 2 | Walker outcome: 0 ok, 1 not present, 2/3 reserved bit |
| is_user | input | 1 | Request made at user privilege |
| acc_type | input | 2 | 0 load, 1 store, 2 fetch, 3 treated as load |
| pg_user | input | 1 | Combined user bit of the walk |
| pg_write | input | 1 | Combined writable bit of the walk |
| pg_nx | input | 1 | Combined no-execute bit of the walk |
| pg_dirty | input | 1 | Dirty bit of the leaf entry |
| pg_key | input | KEY_W | Protection key of the leaf entry |
| sup_guard | input | 1 | Supervisor data access to user pages is prevented in this context |
| exec_guard | input | 1 | Supervisor execution of user pages is prevented |
| wr_protect | input | 1 | Supervisor writes honour read-only pages |
| nx_on | input | 1 | No-execute feature enabled |
| ukey_on | input | 1 | Key rights for user pages enabled |
| skey_on | input | 1 | Key rights for supervisor pages enabled |
| ukey_reg | input | KR_W | Key rights register for user pages |
| skey_reg | input | KR_W | Key rights register for supervisor pages |
| out_valid | output | 1 | Result strobe |
| out_fault | output | 1 | Request denied |
| out_err | output | 6 | Page-fault error code |
| out_rights | output | 3 | Cacheable rights {exec, write, read} |
| out_set_acc | output | 1 | Walker must set the accessed bit |
| out_set_dirty | output | 1 | Walker must set the dirty bit |

## Verification
Every result of this block (fault flag, error code, rights, accessed/dirty requests) is due exactly one clock after the strobe that carried the request. The driver applies each request on a falling edge and queues its predicted result. The monitor compares the head of the queue on the next falling edge that shows `out_valid`, which is half a period after the registering edge. Requests are issued back to back, so a result landing one cycle early or late lines up against the wrong queue entry. A final idle window confirms that `out_valid` stays low and that the other outputs keep their last values.

// File: rtl/page_rights_pkg.sv
package page_rights_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_ALT   = 2'd3
  } acc_t;

  typedef enum logic [1:0] {
    WALK_OK    = 2'd0,
    WALK_ABSENT = 2'd1,
    WALK_RSVD  = 2'd2,
    WALK_RSVD2 = 2'd3
  } walk_t;

  localparam int RIGHTS_W = 3;
  localparam int RT_READ  = 0;
  localparam int RT_WRITE = 1;
  localparam int RT_EXEC  = 2;

  localparam int ERR_W     = 6;
  localparam int EB_PRES   = 0;
  localparam int EB_WRITE  = 1;
  localparam int EB_USER   = 2;
  localparam int EB_RSVD   = 3;
  localparam int EB_FETCH  = 4;
  localparam int EB_KEY    = 5;

  localparam logic [RIGHTS_W-1:0] RIGHTS_ALL = '1;

endpackage

// File: rtl/rights_base.sv
module rights_base
  import page_rights_pkg::*;
(
  input  logic                is_user,
  input  logic                pg_user,
  input  logic                pg_write,
  input  logic                pg_nx,
  input  logic                sup_guard,
  input  logic                exec_guard,
  input  logic                wr_protect,
  output logic [RIGHTS_W-1:0] base_rights
);

  logic rd_ok;
  logic wr_ok;
  logic ex_ok;

  always_comb begin
    // data access blocked when the guard applies to a user page
    rd_ok = !(sup_guard && pg_user);
    // writes need the writable bit, unless a supervisor ignores read-only
    wr_ok = rd_ok && (pg_write || (!is_user && !wr_protect));
    // fetches need NX clear and no supervisor fetch from a guarded user page
    ex_ok = !pg_nx && (is_user || !(exec_guard && pg_user));
    base_rights           = '0;
    base_rights[RT_READ]  = rd_ok;
    base_rights[RT_WRITE] = wr_ok;
    base_rights[RT_EXEC]  = ex_ok;
  end

endmodule

// File: rtl/key_gate.sv
module key_gate
  import page_rights_pkg::*;
#(
  parameter int KEY_W = 4,
  localparam int KR_W = 2 << KEY_W
) (
  input  logic                is_user,
  input  logic                pg_user,
  input  logic                wr_protect,
  input  logic                ukey_on,
  input  logic                skey_on,
  input  logic [KR_W-1:0]     ukey_reg,
  input  logic [KR_W-1:0]     skey_reg,
  input  logic [KEY_W-1:0]    pg_key,
  output logic                key_active,
  output logic [RIGHTS_W-1:0] key_rights
);

  localparam int NKEYS = 1 << KEY_W;

  logic [KR_W-1:0] sel_reg;
  logic [NKEYS-1:0] ad_vec;
  logic [NKEYS-1:0] wd_vec;
  logic ad_bit;
  logic wd_bit;

  always_comb begin
    if (pg_user)
      sel_reg = ukey_on ? ukey_reg : '0;
    else
      sel_reg = skey_on ? skey_reg : '0;
  end

  // split the register into per-key disable vectors
  for (genvar k = 0; k < NKEYS; k++) begin : g_pair
    assign ad_vec[k] = sel_reg[2*k];
    assign wd_vec[k] = sel_reg[2*k+1];
  end

  assign ad_bit     = ad_vec[pg_key];
  assign wd_bit     = wd_vec[pg_key];
  assign key_active = |sel_reg;

  always_comb begin
    key_rights = RIGHTS_ALL;
    if (key_active) begin
      if (ad_bit) begin
        key_rights[RT_READ]  = 1'b0;
        key_rights[RT_WRITE] = 1'b0;
      end else if (wd_bit && (is_user || wr_protect)) begin
        key_rights[RT_WRITE] = 1'b0;
      end
    end
  end

endmodule

// File: rtl/fault_code.sv
module fault_code
  import page_rights_pkg::*;
(
  input  walk_t               walk_status,
  input  logic                is_user,
  input  logic                pg_user,
  input  logic                pg_dirty,
  input  acc_t                acc,
  input  logic                nx_on,
  input  logic                exec_guard,
  input  logic                key_active,
  input  logic [RIGHTS_W-1:0] key_rights,
  input  logic [RIGHTS_W-1:0] base_rights,
  output logic                fault,
  output logic [ERR_W-1:0]    err,
  output logic [RIGHTS_W-1:0] rights,
  output logic                set_acc,
  output logic                set_dirty
);

  logic [RIGHTS_W-1:0] merged;
  logic [1:0]          idx;
  logic                is_store;
  logic                is_fetch;
  logic [ERR_W-1:0]    core;

  assign merged   = base_rights & key_rights;
  assign idx      = acc[1:0];
  assign is_store = (acc == ACC_STORE);
  assign is_fetch = (acc == ACC_FETCH);

  always_comb begin
    fault = 1'b1;
    core  = '0;
    if (walk_status == WALK_ABSENT) begin
      core = '0;
    end else if (walk_status == WALK_RSVD || walk_status == WALK_RSVD2) begin
      core[EB_RSVD] = 1'b1;
    end else if (is_user && !pg_user) begin
      core[EB_PRES] = 1'b1;
    end else if (key_active && !key_rights[idx]) begin
      core[EB_PRES] = 1'b1;
      core[EB_KEY]  = 1'b1;
    end else if (!merged[idx]) begin
      core[EB_PRES] = 1'b1;
    end else begin
      fault = 1'b0;
    end
  end

  always_comb begin
    err = '0;
    if (fault) begin
      err = core;
      err[EB_USER]  = is_user;
      err[EB_WRITE] = is_store;
      err[EB_FETCH] = is_fetch && (nx_on || exec_guard);
    end
  end

  always_comb begin
    rights    = '0;
    set_acc   = 1'b0;
    set_dirty = 1'b0;
    if (!fault) begin
      rights    = merged;
      set_acc   = 1'b1;
      set_dirty = is_store;
      if (!is_store && !pg_dirty)
        rights[RT_WRITE] = 1'b0;
    end
  end

endmodule

// File: rtl/page_rights_unit.sv
module page_rights_unit
  import page_rights_pkg::*;
#(
  parameter int KEY_W = 4,
  localparam int KR_W = 2 << KEY_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [1:0]       walk_status,
  input  logic             is_user,
  input  logic [1:0]       acc_type,
  input  logic             pg_user,
  input  logic             pg_write,
  input  logic             pg_nx,
  input  logic             pg_dirty,
  input  logic [KEY_W-1:0] pg_key,
  input  logic             sup_guard,
  input  logic             exec_guard,
  input  logic             wr_protect,
  input  logic             nx_on,
  input  logic             ukey_on,
  input  logic             skey_on,
  input  logic [KR_W-1:0]  ukey_reg,
  input  logic [KR_W-1:0]  skey_reg,
  output logic             out_valid,
  output logic             out_fault,
  output logic [5:0]       out_err,
  output logic [2:0]       out_rights,
  output logic             out_set_acc,
  output logic             out_set_dirty
);

  acc_t                acc_n;
  logic [RIGHTS_W-1:0] base_r;
  logic [RIGHTS_W-1:0] key_r;
  logic                key_act;
  logic                c_fault;
  logic [ERR_W-1:0]    c_err;
  logic [RIGHTS_W-1:0] c_rights;
  logic                c_acc;
  logic                c_dirty;

  // the spare access code behaves as a load
  assign acc_n = (acc_type == 2'd3) ? ACC_LOAD : acc_t'(acc_type);

  rights_base u_base (
    .is_user     (is_user),
    .pg_user     (pg_user),
    .pg_write    (pg_write),
    .pg_nx       (pg_nx),
    .sup_guard   (sup_guard),
    .exec_guard  (exec_guard),
    .wr_protect  (wr_protect),
    .base_rights (base_r)
  );

  key_gate #(.KEY_W(KEY_W)) u_key (
    .is_user    (is_user),
    .pg_user    (pg_user),
    .wr_protect (wr_protect),
    .ukey_on    (ukey_on),
    .skey_on    (skey_on),
    .ukey_reg   (ukey_reg),
    .skey_reg   (skey_reg),
    .pg_key     (pg_key),
    .key_active (key_act),
    .key_rights (key_r)
  );

  fault_code u_code (
    .walk_status (walk_t'(walk_status)),
    .is_user     (is_user),
    .pg_user     (pg_user),
    .pg_dirty    (pg_dirty),
    .acc         (acc_n),
    .nx_on       (nx_on),
    .exec_guard  (exec_guard),
    .key_active  (key_act),
    .key_rights  (key_r),
    .base_rights (base_r),
    .fault       (c_fault),
    .err         (c_err),
    .rights      (c_rights),
    .set_acc     (c_acc),
    .set_dirty   (c_dirty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_fault     <= 1'b0;
      out_err       <= '0;
      out_rights    <= '0;
      out_set_acc   <= 1'b0;
      out_set_dirty <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_fault     <= c_fault;
        out_err       <= c_err;
        out_rights    <= c_rights;
        out_set_acc   <= c_acc;
        out_set_dirty <= c_dirty;
      end
    end
  end

  // R11
  strobe_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R11
  strobe_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_err) && $stable(out_rights)));

  // R10
  fault_no_rights_chk: assert property (@(posedge clk) disable iff (rst)
    out_fault |-> (out_rights == '0 && !out_set_acc && !out_set_dirty));

  // R9
  grant_sets_acc_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_fault) |-> out_set_acc);

  // R9
  dirty_has_write_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_set_dirty) |-> out_rights[RT_WRITE]);

  // R6
  key_err_present_chk: assert property (@(posedge clk) disable iff (rst)
    (out_fault && out_err[EB_KEY]) |-> out_err[EB_PRES]);

  // R7
  rsvd_not_present_chk: assert property (@(posedge clk) disable iff (rst)
    (out_fault && out_err[EB_RSVD]) |-> !out_err[EB_PRES]);

endmodule

// File: tb/page_rights_unit_test.sv
module page_rights_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam int KEY_W = 4;
  localparam int KR_W  = 2 << KEY_W;

  typedef struct {
    logic [1:0] walk;
    logic user;
    logic [1:0] acc;
    logic pu, pw, pnx, pd;
    logic [KEY_W-1:0] key;
    logic sg, eg, wp, nxe, uke, ske;
    logic [KR_W-1:0] ukr, skr;
  } stim_t;

  typedef struct {
    logic fault;
    logic [5:0] err;
    logic [2:0] rights;
    logic sa, sd;
    string tag;
  } exp_t;

  logic clk = 0;
  logic rst = 1;
  logic in_valid = 0;
  logic [1:0] walk_status = 0;
  logic is_user = 0;
  logic [1:0] acc_type = 0;
  logic pg_user = 0, pg_write = 0, pg_nx = 0, pg_dirty = 0;
  logic [KEY_W-1:0] pg_key = 0;
  logic sup_guard = 0, exec_guard = 0, wr_protect = 0, nx_on = 0;
  logic ukey_on = 0, skey_on = 0;
  logic [KR_W-1:0] ukey_reg = 0, skey_reg = 0;
  logic out_valid, out_fault, out_set_acc, out_set_dirty;
  logic [5:0] out_err;
  logic [2:0] out_rights;

  int checks = 0;
  int fails = 0;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  page_rights_unit #(.KEY_W(KEY_W)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .walk_status(walk_status),
    .is_user(is_user), .acc_type(acc_type), .pg_user(pg_user),
    .pg_write(pg_write), .pg_nx(pg_nx), .pg_dirty(pg_dirty), .pg_key(pg_key),
    .sup_guard(sup_guard), .exec_guard(exec_guard), .wr_protect(wr_protect),
    .nx_on(nx_on), .ukey_on(ukey_on), .skey_on(skey_on),
    .ukey_reg(ukey_reg), .skey_reg(skey_reg), .out_valid(out_valid),
    .out_fault(out_fault), .out_err(out_err), .out_rights(out_rights),
    .out_set_acc(out_set_acc), .out_set_dirty(out_set_dirty)
  );

  // Prediction straight from the requirement list
  function automatic exp_t predict(stim_t s, string tag);
    exp_t e;
    logic [KR_W-1:0] kreg;
    logic [2:0] base, kr, fin;
    logic [1:0] a;
    logic rd, wr, ex;
    a = (s.acc == 2'd3) ? 2'd0 : s.acc;
    kreg = s.pu ? (s.uke ? s.ukr : '0) : (s.ske ? s.skr : '0);
    rd = !(s.sg && s.pu);
    wr = rd && (s.pw || (!s.user && !s.wp));
    ex = !s.pnx && (s.user || !(s.eg && s.pu));
    base = {ex, wr, rd};
    kr = 3'b111;
    if (kreg != 0) begin
      if (kreg[2*s.key]) kr = 3'b100;
      else if (kreg[2*s.key+1] && (s.user || s.wp)) kr = 3'b101;
    end
    fin = base & kr;
    e.tag = tag;
    e.fault = 1; e.err = 0; e.rights = 0; e.sa = 0; e.sd = 0;
    if (s.walk == 2'd1) e.err = 6'h00;
    else if (s.walk[1]) e.err = 6'h08;
    else if (s.user && !s.pu) e.err = 6'h01;
    else if (kreg != 0 && !kr[a]) e.err = 6'h21;
    else if (!fin[a]) e.err = 6'h01;
    else e.fault = 0;
    if (e.fault) begin
      if (s.user) e.err |= 6'h04;
      if (a == 2'd1) e.err |= 6'h02;
      if (a == 2'd2 && (s.nxe || s.eg)) e.err |= 6'h10;
    end else begin
      e.rights = fin;
      e.sa = 1;
      e.sd = (a == 2'd1);
      if (a != 2'd1 && !s.pd) e.rights[1] = 0;
    end
    return e;
  endfunction

  task automatic drive(stim_t s, string tag);
    @(negedge clk);
    walk_status = s.walk; is_user = s.user; acc_type = s.acc;
    pg_user = s.pu; pg_write = s.pw; pg_nx = s.pnx; pg_dirty = s.pd;
    pg_key = s.key; sup_guard = s.sg; exec_guard = s.eg; wr_protect = s.wp;
    nx_on = s.nxe; ukey_on = s.uke; skey_on = s.ske;
    ukey_reg = s.ukr; skey_reg = s.skr;
    in_valid = 1;
    sb.push_back(predict(s, tag));
  endtask

  task automatic check(logic ok, string tag, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // Monitor: results are due on the falling edge after the registering edge
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && out_valid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R11", "unexpected out_valid", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(out_fault == e.fault && out_err == e.err &&
                out_rights == e.rights && out_set_acc == e.sa &&
                out_set_dirty == e.sd, e.tag, "{fault,err,rights,acc,dirty}",
                {out_fault, out_err, out_rights, out_set_acc, out_set_dirty},
                {e.fault, e.err, e.rights, e.sa, e.sd});
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  function automatic stim_t dflt();
    stim_t s;
    s.walk = 0; s.user = 0; s.acc = 0; s.pu = 0; s.pw = 1; s.pnx = 0; s.pd = 1;
    s.key = 0; s.sg = 0; s.eg = 0; s.wp = 0; s.nxe = 0; s.uke = 0; s.ske = 0;
    s.ukr = 0; s.skr = 0;
    return s;
  endfunction

  initial begin
    stim_t s;
    logic [5:0] last_err;
    logic [2:0] last_rights;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12: reset state
    check(!out_valid && !out_fault && out_err == 0 && out_rights == 0 &&
          !out_set_acc && !out_set_dirty, "R12", "reset outputs",
          {out_valid, out_fault, out_err, out_rights}, 0);
    rst = 0;

    s = dflt(); drive(s, "R2");                         // full rights
    s = dflt(); s.pd = 0; drive(s, "R9");               // clean load drops write
    s = dflt(); s.pd = 0; s.acc = 1; drive(s, "R9");    // store sets dirty
    s = dflt(); s.user = 1; drive(s, "R1");             // user to supervisor page
    s = dflt(); s.pu = 1; s.sg = 1; drive(s, "R2");     // guarded read
    s = dflt(); s.user = 1; s.pu = 1; s.pw = 0; s.acc = 1; drive(s, "R3");
    s = dflt(); s.pw = 0; s.acc = 1; drive(s, "R3");    // sup write, wp off
    s = dflt(); s.pw = 0; s.acc = 1; s.wp = 1; drive(s, "R3");
    s = dflt(); s.pu = 1; s.eg = 1; s.acc = 2; drive(s, "R4");
    s = dflt(); s.pnx = 1; s.acc = 2; drive(s, "R4");   // no fetch bit
    s = dflt(); s.user = 1; s.pu = 1; s.eg = 1; s.acc = 2; drive(s, "R4");
    s = dflt(); s.pnx = 1; s.nxe = 1; s.acc = 2; drive(s, "R8");
    s = dflt(); s.user = 1; s.pu = 1; s.uke = 1; s.key = 5;
      s.ukr = 32'h1 << 10; drive(s, "R5");              // access disable
    s.uke = 0; drive(s, "R5");                          // feature off
    s = dflt(); s.ske = 1; s.key = 3; s.skr = 32'h1 << 6;
      s.ukr = 32'hffff_ffff; s.uke = 1; drive(s, "R5"); // supervisor register
    s = dflt(); s.user = 1; s.pu = 1; s.uke = 1; s.key = 7;
      s.ukr = 32'h1 << 15; drive(s, "R6");              // write disable on load
    s.acc = 1; drive(s, "R6");                          // write disable on store
    s = dflt(); s.ske = 1; s.key = 2; s.skr = 32'h1 << 5; s.acc = 1;
      drive(s, "R6");                                   // sup, wp off: allowed
    s.wp = 1; drive(s, "R6");                           // sup, wp on: denied
    s = dflt(); s.walk = 1; s.user = 1; s.pu = 1; s.acc = 1; drive(s, "R7");
    s = dflt(); s.walk = 2; s.acc = 2; s.nxe = 1; drive(s, "R7");
    s = dflt(); s.walk = 3; s.user = 1; drive(s, "R7"); // priority over R1
    s = dflt(); s.user = 1; s.pu = 1; s.acc = 3; s.pd = 0; drive(s, "R10");
    s = dflt(); s.user = 1; s.acc = 3; drive(s, "R10");
    @(negedge clk);
    in_valid = 0;
    while (sb.size() != 0) @(negedge clk);
    last_err = out_err;
    last_rights = out_rights;
    // R11: outputs hold while idle
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(!out_valid && out_err == last_err && out_rights == last_rights,
            "R11", "idle hold", {out_valid, out_err, out_rights},
            {1'b0, last_err, last_rights});
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule